// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block keeps track of the bit position inside a serial audio frame and produces the frame-sync line for stereo, left/right-justified, DSP-pulse and multi-slot framing. The block runs on a fast system clock. The bit clock enters as an ordinary signal and is edge-detected. The bit clock can come from a locally generated source, or it can come from an external pin that is resynchronized first. Frame sync can be generated locally, or the block can follow an external frame-sync line. These two choices are independent, so all four combinations are allowed.

Software programs the frame length minus one and the number of bit clocks for which sync stays active. These two values are set separately, so the same block can produce a 50% duty left/right clock or a single-bit pulse. A polarity select chooses which sync edge marks the frame start. A sampling-edge select chooses which bit-clock edge advances the counter. When frame sync is external, the counter restarts on each detected frame start, and a sticky flag reports frames of the wrong length. A disable input parks the whole block in its idle state. The channel formatter downstream uses the bit position output to place its data.

Top module: `fsg_frame_sync_gen`

## Requirements
- R1: After reset, bit_pos_o is 0, frame_err_o is 0, and fs_o is at its idle level. The idle level is 0 when fs_inv_i=0 and 1 when fs_inv_i=1.
- R2: With local frame sync (fs_slave_i=0), the first active bit-clock edge after reset or after disable gives bit_pos_o=0. Each later active edge adds one. After frame_len_m1_i the count returns to 0, so a frame is frame_len_m1_i+1 bits long.
- R3: With local frame sync, the sync line is active exactly on the bits whose position is below sync_len_i. A value of 1 gives a single-bit pulse, and half the frame length gives a 50% duty clock.
- R4: fs_inv_i=1 inverts fs_o. The active level becomes 0, so the frame starts on a falling edge of fs_o, and the idle level becomes 1.
- R5: samp_fall_i=0 makes the rising bit-clock edge the active edge. samp_fall_i=1 makes the falling edge the active edge. The other edge has no effect on bit_pos_o.
- R6: bclk_slave_i=1 takes the bit clock from ext_bclk_i through a synchronizer. bclk_slave_i=0 takes it from loc_bclk_i. Toggling the input that is not selected leaves bit_pos_o unchanged.
- R7: With fs_slave_i=1, fs_o stays at its idle level. Before the first frame start, bit_pos_o stays 0. A frame start is a 0-to-1 change of ext_fs_i (a 1-to-0 change when fs_inv_i=1), sampled on active bit-clock edges. The bit on which the start is seen has bit_pos_o=0, and the following bits count up by one.
- R8: With fs_slave_i=1, frame_err_o is set and stays set in two cases. The first is a frame start seen at a bit whose previous position was not frame_len_m1_i. The second is a missing start on the bit after frame_len_m1_i. Local frame sync never sets frame_err_o.
- R9: While clk_dis_i=1, bit_pos_o is 0, fs_o is idle and frame_err_o is cleared, and active bit-clock edges are ignored.
- R10: frame_len_m1_i=1023 gives a frame of 1024 bits, and bit_pos_o wraps from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_dis_i | input | 1 | Hold block idle |
| bclk_slave_i | input | 1 | 1: bit clock from ext_bclk_i |
| fs_slave_i | input | 1 | 1: follow ext_fs_i |
| fs_inv_i | input | 1 | 1: frame starts on falling sync edge |
| samp_fall_i | input | 1 | 1: falling bit-clock edge is active |
| frame_len_m1_i | input | 10 | Frame length minus one |
| sync_len_i | input | 10 | Sync active length in bits |
| loc_bclk_i | input | 1 | Local bit clock level |
| ext_bclk_i | input | 1 | External bit clock pin |
| ext_fs_i | input | 1 | External frame sync pin |
| fs_o | output | 1 | Frame sync output |
| bit_pos_o | output | 10 | Bit position in frame |
| frame_err_o | output | 1 | Sticky wrong-length frame flag |

## Verification
The bench builds the block with its default parameters: 10-bit length fields and a two-stage synchronizer. Because of this, the largest frame of 1024 bits can be reached, and the wrap from 1023 to 0 is checked directly. The same synchronizer depth is applied to the external bit clock and to the external sync, so the bench exercises all four combinations of local and external sources with one stimulus timing. Short and long external frames, both sync polarities and both sampling edges are each driven in their own scenario.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int unsigned LEN_W_DEF = 10;
  localparam int unsigned SYNC_DEF  = 2;
endpackage

// File: rtl/fsg_sync.sv
module fsg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_chain
      logic [STAGES-1:0] q_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= {q_q[STAGES-2:0], d_i};
      end
      assign q_o = q_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fsg_bclk_edge.sv
module fsg_bclk_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_bclk_i,
  input  logic ext_bclk_i,
  input  logic sel_ext_i,
  input  logic samp_fall_i,
  output logic tick_o
);
  logic ext_s;
  logic lvl;
  logic prev_q;
  logic prev_n;

  fsg_sync #(.STAGES(SYNC_STAGES)) u_bsync (
    .clk(clk), .rst_n(rst_n), .d_i(ext_bclk_i), .q_o(ext_s)
  );

  always_comb begin
    lvl    = sel_ext_i ? ext_s : loc_bclk_i;
    prev_n = lvl;
    if (samp_fall_i) tick_o = prev_q & ~lvl;
    else             tick_o = lvl & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_n;
  end
endmodule

// File: rtl/fsg_counter.sv
module fsg_counter #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             dis_i,
  input  logic             fs_slave_i,
  input  logic             fs_lvl_i,
  input  logic [LEN_W-1:0] flen_m1_i,
  input  logic [LEN_W-1:0] sync_len_i,
  output logic [LEN_W-1:0] cnt_o,
  output logic             act_o,
  output logic             err_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic act_q, act_n, lock_q, lock_n, err_q, err_n, fsp_q, fsp_n;
  logic start;

  assign start = fs_lvl_i & ~fsp_q;

  always_comb begin
    cnt_n  = cnt_q;
    act_n  = act_q;
    lock_n = lock_q;
    err_n  = err_q;
    fsp_n  = tick_i ? fs_lvl_i : fsp_q;
    if (dis_i) begin
      cnt_n  = '0;
      act_n  = 1'b0;
      lock_n = 1'b0;
      err_n  = 1'b0;
    end else if (!fs_slave_i) begin
      if (tick_i) begin
        if (!lock_q || cnt_q >= flen_m1_i) cnt_n = '0;
        else                               cnt_n = cnt_q + ONE;
        lock_n = 1'b1;
        act_n  = (cnt_n < sync_len_i);
      end
    end else begin
      act_n = 1'b0;
      if (tick_i) begin
        if (start) begin
          cnt_n  = '0;
          lock_n = 1'b1;
          if (lock_q && cnt_q != flen_m1_i) err_n = 1'b1;
        end else if (lock_q) begin
          if (cnt_q >= flen_m1_i) begin
            cnt_n = '0;
            err_n = 1'b1;
          end else begin
            cnt_n = cnt_q + ONE;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      lock_q <= 1'b0;
      err_q  <= 1'b0;
      fsp_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      lock_q <= lock_n;
      err_q  <= err_n;
      fsp_q  <= fsp_n;
    end
  end

  assign cnt_o = cnt_q;
  assign act_o = act_q;
  assign err_o = err_q;
endmodule

// File: rtl/fsg_frame_sync_gen.sv
module fsg_frame_sync_gen #(
  parameter int unsigned LEN_W       = fsg_pkg::LEN_W_DEF,
  parameter int unsigned SYNC_STAGES = fsg_pkg::SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_dis_i,
  input  logic             bclk_slave_i,
  input  logic             fs_slave_i,
  input  logic             fs_inv_i,
  input  logic             samp_fall_i,
  input  logic [LEN_W-1:0] frame_len_m1_i,
  input  logic [LEN_W-1:0] sync_len_i,
  input  logic             loc_bclk_i,
  input  logic             ext_bclk_i,
  input  logic             ext_fs_i,
  output logic             fs_o,
  output logic [LEN_W-1:0] bit_pos_o,
  output logic             frame_err_o
);
  logic [1:0] rst_q;
  logic       rst_int_n;
  logic       tick;
  logic       ext_fs_s;
  logic       act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  fsg_bclk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_int_n),
    .loc_bclk_i(loc_bclk_i), .ext_bclk_i(ext_bclk_i),
    .sel_ext_i(bclk_slave_i), .samp_fall_i(samp_fall_i),
    .tick_o(tick)
  );

  fsg_sync #(.STAGES(SYNC_STAGES)) u_fsync (
    .clk(clk), .rst_n(rst_int_n), .d_i(ext_fs_i), .q_o(ext_fs_s)
  );

  fsg_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .tick_i(tick), .dis_i(clk_dis_i),
    .fs_slave_i(fs_slave_i), .fs_lvl_i(ext_fs_s ^ fs_inv_i),
    .flen_m1_i(frame_len_m1_i), .sync_len_i(sync_len_i),
    .cnt_o(bit_pos_o), .act_o(act), .err_o(frame_err_o)
  );

  assign fs_o = act ^ fs_inv_i;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker #(
  parameter int unsigned LEN_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clk_dis_i,
  input logic             fs_slave_i,
  input logic             fs_inv_i,
  input logic [LEN_W-1:0] frame_len_m1_i,
  input logic             fs_o,
  input logic [LEN_W-1:0] bit_pos_o,
  input logic             frame_err_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  p_dis_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clk_dis_i |=> (bit_pos_o == '0) && !frame_err_o && (fs_o == fs_inv_i));

  p_slave_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_slave_i && $past(fs_slave_i)) |-> (fs_o == fs_inv_i));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_pos_o) |-> (bit_pos_o == '0) || (bit_pos_o == $past(bit_pos_o) + ONE));

  p_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_dis_i && $stable(frame_len_m1_i)) |-> (bit_pos_o <= frame_len_m1_i));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_err_o && !clk_dis_i) |=> frame_err_o);

  p_local_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fs_slave_i && !frame_err_o) |=> !frame_err_o);
endmodule

bind fsg_frame_sync_gen fsg_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_dis_i(clk_dis_i), .fs_slave_i(fs_slave_i),
  .fs_inv_i(fs_inv_i), .frame_len_m1_i(frame_len_m1_i), .fs_o(fs_o),
  .bit_pos_o(bit_pos_o), .frame_err_o(frame_err_o)
);

// File: tb/fsg_frame_sync_gen_test.sv
module fsg_frame_sync_gen_test;
  logic clk = 1'b0;
  logic rst_n;
  logic clk_dis, bclk_slave, fs_slave, fs_inv, samp_fall;
  logic [9:0] flen, slen;
  logic loc_bclk, ext_bclk, ext_fs;
  logic fs_o, err_o;
  logic [9:0] pos_o;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fsg_frame_sync_gen uut (
    .clk(clk), .rst_n(rst_n), .clk_dis_i(clk_dis), .bclk_slave_i(bclk_slave),
    .fs_slave_i(fs_slave), .fs_inv_i(fs_inv), .samp_fall_i(samp_fall),
    .frame_len_m1_i(flen), .sync_len_i(slen), .loc_bclk_i(loc_bclk),
    .ext_bclk_i(ext_bclk), .ext_fs_i(ext_fs), .fs_o(fs_o),
    .bit_pos_o(pos_o), .frame_err_o(err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_bclk(input logic v);
    if (bclk_slave) ext_bclk = v; else loc_bclk = v;
  endtask

  // one bit: inactive edge (sync changes), then active edge, then settle
  task automatic bit_step(input logic fs_val);
    @(negedge clk);
    ext_fs = fs_val;
    set_bclk(samp_fall);
    repeat (5) @(negedge clk);
    set_bclk(~samp_fall);
    repeat (5) @(negedge clk);
  endtask

  task automatic config_(input logic bs, input logic fss, input logic inv,
                         input logic sf, input int fl, input int sl);
    @(negedge clk);
    clk_dis = 1'b1;
    bclk_slave = bs; fs_slave = fss; fs_inv = inv; samp_fall = sf;
    flen = 10'(fl); slen = 10'(sl);
    loc_bclk = sf ? 1'b0 : 1'b1; ext_bclk = loc_bclk; ext_fs = inv;
    repeat (6) @(negedge clk);
    clk_dis = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 pos", pos_o, 0);
    chk("R1 fs", fs_o, 0);
    chk("R1 err", err_o, 0);
  endtask

  task automatic t_master_lr;
    config_(0, 0, 0, 0, 7, 4);
    for (int k = 0; k < 20; k++) begin
      bit_step(1'b0);
      chk("R2 pos", pos_o, k % 8);
      chk("R3 fs 50%", fs_o, ((k % 8) < 4) ? 1 : 0);
    end
    chk("R8 no err local", err_o, 0);
  endtask

  task automatic t_master_pulse;
    config_(0, 0, 0, 0, 5, 1);
    for (int k = 0; k < 13; k++) begin
      bit_step(1'b0);
      chk("R2 pos len6", pos_o, k % 6);
      chk("R3 pulse", fs_o, ((k % 6) == 0) ? 1 : 0);
    end
  endtask

  task automatic t_invert;
    config_(0, 0, 1, 0, 3, 2);
    chk("R4 idle high", fs_o, 1);
    for (int k = 0; k < 8; k++) begin
      bit_step(1'b1);
      chk("R4 inv fs", fs_o, ((k % 4) < 2) ? 0 : 1);
    end
  endtask

  task automatic t_fall_edge;
    config_(0, 0, 0, 1, 7, 4);
    bit_step(1'b0);
    chk("R5 fall first", pos_o, 0);
    bit_step(1'b0);
    chk("R5 fall second", pos_o, 1);
    @(negedge clk); loc_bclk = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5 rising ignored", pos_o, 1);
    @(negedge clk); loc_bclk = 1'b0;
    repeat (6) @(negedge clk);
    chk("R5 falling counted", pos_o, 2);
  endtask

  task automatic t_ext_bclk;
    config_(1, 0, 0, 0, 7, 4);
    for (int k = 0; k < 10; k++) begin
      bit_step(1'b0);
      chk("R6 ext pos", pos_o, k % 8);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); loc_bclk = ~loc_bclk;
      repeat (5) @(negedge clk);
    end
    chk("R6 loc ignored", pos_o, 1);
  endtask

  task automatic t_slave_fs(input logic bs, input logic inv);
    config_(bs, 1, inv, 0, 7, 4);
    for (int k = 0; k < 3; k++) begin
      bit_step(inv);
      chk("R7 wait pos", pos_o, 0);
    end
    for (int k = 0; k < 24; k++) begin
      bit_step(((k % 8) < 4) ? ~inv : inv);
      chk("R7 slave pos", pos_o, k % 8);
      chk("R7 fs idle", fs_o, inv);
    end
    chk("R8 good frames", err_o, 0);
  endtask

  task automatic t_short_long;
    config_(0, 1, 0, 0, 7, 4);
    bit_step(1'b1);
    for (int k = 1; k < 5; k++) bit_step(1'b0);
    chk("R8 before short", err_o, 0);
    bit_step(1'b1);
    chk("R8 short frame", err_o, 1);
    chk("R7 restart", pos_o, 0);
    bit_step(1'b0);
    chk("R8 sticky", err_o, 1);
    @(negedge clk); clk_dis = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 err cleared", err_o, 0);
    chk("R9 pos zero", pos_o, 0);
    bit_step(1'b1);
    chk("R9 edges ignored", pos_o, 0);
    @(negedge clk); clk_dis = 1'b0;
    bit_step(1'b0);
    bit_step(1'b1);
    for (int k = 1; k < 8; k++) bit_step(1'b0);
    chk("R8 before long", err_o, 0);
    chk("R8 at last bit", pos_o, 7);
    bit_step(1'b0);
    chk("R8 long frame", err_o, 1);
  endtask

  task automatic t_dis_inv;
    config_(0, 0, 1, 0, 7, 4);
    bit_step(1'b1);
    bit_step(1'b1);
    @(negedge clk); clk_dis = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle inv", fs_o, 1);
    chk("R9 pos", pos_o, 0);
    @(negedge clk); clk_dis = 1'b0;
    bit_step(1'b1);
    chk("R9 restart at 0", pos_o, 0);
  endtask

  task automatic t_max;
    config_(0, 0, 0, 0, 1023, 512);
    for (int k = 0; k < 1026; k++) begin
      bit_step(1'b0);
      if (k == 511) chk("R10 fs at 511", fs_o, 1);
      if (k == 512) chk("R10 fs at 512", fs_o, 0);
      if (k == 1023) chk("R10 pos 1023", pos_o, 1023);
      if (k == 1024) chk("R10 wrap", pos_o, 0);
      if (k == 1025) chk("R10 after wrap", pos_o, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clk_dis = 1'b0; bclk_slave = 1'b0; fs_slave = 1'b0;
    fs_inv = 1'b0; samp_fall = 1'b0; flen = 10'd7; slen = 10'd4;
    loc_bclk = 1'b0; ext_bclk = 1'b0; ext_fs = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_master_lr();
    t_master_pulse();
    t_invert();
    t_fall_edge();
    t_ext_bclk();
    t_slave_fs(1'b0, 1'b0);
    t_slave_fs(1'b1, 1'b1);
    t_short_long();
    t_dis_inv();
    t_max();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule